// File: doc/BRIEF.md
# Camera Control Bus Register Access Master

This block is the master side of the two-wire serial control bus that sets up an image sensor. Each request reads or writes one 8-bit sensor register. The requester pulses `start` together with a read/write select, a register address and, for writes, a data byte. The block then runs the whole bus sequence by itself. When it finishes it pulses `done`, reports whether every byte it sent was acknowledged, and for a read returns the byte it fetched.

A write is one framed transfer: the device write address, the register address, then the value. A read takes two framed transfers. The first carries the device write address and the register address and then stops. The second begins with a fresh start and carries the device read address. The slave then returns one byte, which the master answers with a not-acknowledge before it stops.

SCL is produced from the system clock through a quarter-period divider, so one SCL period is four quarters. Data changes at the middle of the SCL low time and is sampled at the middle of the high time. SDA leaves the block as a value plus an output enable for a pad-level tri-state buffer, and the bus level comes back on `sda_i`. The master never waits for SCL to be held low by the slave.

Top module: `cam2w_master`

## Requirements
- R1: After reset the block is idle: `busy`=0, `done`=0, `ack_ok`=0, `rd_data`=0x00, `scl_o`=1, `sda_oe`=1 and `sda_o`=1.
- R2: `start` is accepted only while `busy`=0, and the request fields are captured on that edge. A `start` pulse during a transfer, with any field values, changes neither the running transfer nor its latency or results.
- R3: A write (`rd_nwr`=0) produces exactly one start, the bytes 0x42, address and data, and one stop. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high.
- R4: A read (`rd_nwr`=1) sends a start, 0x42, the address and a stop. It then sends a second start and 0x43, and shifts in one byte. At `done`, `rd_data` holds that byte.
- R5: Bytes go out most significant bit first. While SCL is high, SDA changes only to form a start or a stop.
- R6: The master releases SDA (`sda_oe`=0) for the ninth bit of each byte it sends and for the eight data bits of the read byte. In the ninth bit of the read byte it drives SDA high.
- R7: `ack_ok` is 1 only if every byte the master sent saw SDA low in its ninth bit. A missing acknowledge does not shorten the sequence.
- R8: `done` is a single-cycle pulse on the edge that is 116·Q clock cycles (write) or 160·Q cycles (read) after the accepting edge, where Q = `SYS_CLK_HZ`/(4·`SCL_HZ`). `busy` is high from the accepting edge until that edge.
- R9: Inside a byte, consecutive SCL rising edges are 4·Q clock cycles apart.
- R10: `ack_ok` and `rd_data` change only on a `done` edge. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| rd_nwr | input | 1 | 1 = register read, 0 = register write |
| reg_addr | input | 8 | Sensor register address |
| wr_data | input | 8 | Value for a write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| ack_ok | output | 1 | All sent bytes acknowledged in the last transfer |
| rd_data | output | 8 | Byte returned by the last read |
| scl_o | output | 1 | Serial clock |
| sda_o | output | 1 | SDA value when driven |
| sda_oe | output | 1 | SDA driver enable |
| sda_i | input | 1 | Sensed SDA bus level |

## Verification
With Q = 4, `done` is due 464 cycles after the accepting edge for a write and 640 for a read. The bench counts clock edges from that edge and checks `done` one cycle before the due edge and again on it. It reads the bus results only after that edge, and a slave model on the pins checks start/stop counts, the stored bytes and the master's ninth bit. The slave model drives its bits Q+1 cycles after each SCL falling edge, after the master has released SDA and well before the master samples at mid-high. SCL spacing is measured at the second rising edge of the first byte.

// File: rtl/cam2w_pkg.sv
package cam2w_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WBYTE = 2'd1,
        OP_RBYTE = 2'd2,
        OP_STOP  = 2'd3
    } cam2w_op_e;

    // Sequencer state
    typedef struct packed {
        logic       busy;
        logic       rd;
        logic [2:0] step;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic       ack_acc;
        logic       ack_ok;
        logic [7:0] rdata;
        logic       done;
    } seq_s;

    // Bit engine state plus registered pins
    typedef struct packed {
        logic [1:0] qidx;
        logic [3:0] bidx;
        logic [7:0] rx;
        logic       ninth;
        logic       scl;
        logic       sdo;
        logic       soe;
        logic       cond;
    } phy_s;

    function automatic cam2w_op_e step_op(input logic rd, input logic [2:0] step);
        cam2w_op_e r;
        if (!rd) begin
            case (step)
                3'd0:                r = OP_START;
                3'd1, 3'd2, 3'd3:    r = OP_WBYTE;
                default:             r = OP_STOP;
            endcase
        end else begin
            case (step)
                3'd0, 3'd4:          r = OP_START;
                3'd1, 3'd2, 3'd5:    r = OP_WBYTE;
                3'd6:                r = OP_RBYTE;
                default:             r = OP_STOP;
            endcase
        end
        return r;
    endfunction

    function automatic logic [2:0] final_step(input logic rd);
        return rd ? 3'd7 : 3'd4;
    endfunction

endpackage

// File: rtl/cam2w_qtick.sv
module cam2w_qtick #(
    parameter int QTR_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = RELOAD;
        end else if (run) begin
            cnt_d = (cnt_q == '0) ? RELOAD : cnt_q - 1'b1;
        end
    end

    assign tick = run && !restart && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R9

endmodule

// File: rtl/cam2w_phy.sv
module cam2w_phy
    import cam2w_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       clear,
    input  logic       tick,
    input  cam2w_op_e  op,
    input  logic [7:0] tx_byte,
    input  logic       sda_i,
    output logic       cmd_end,
    output logic [7:0] rx_byte,
    output logic       ninth,
    output logic       scl_o,
    output logic       sda_o,
    output logic       sda_oe
);
    phy_s q, n;
    logic byte_op;
    logic last_bit;

    always_comb begin
        n        = q;
        byte_op  = (op == OP_WBYTE) || (op == OP_RBYTE);
        last_bit = (q.bidx == 4'd8);
        cmd_end  = tick && (q.qidx == 2'd3) && (!byte_op || last_bit);

        if (clear) begin
            n.qidx = '0;
            n.bidx = '0;
        end else if (tick) begin
            // mid-high sampling point: end of quarter 1
            if (byte_op && q.qidx == 2'd1) begin
                if (!last_bit) begin
                    if (op == OP_RBYTE) n.rx = {q.rx[6:0], sda_i};
                end else if (op == OP_WBYTE) begin
                    n.ninth = sda_i;
                end
            end
            n.qidx = q.qidx + 2'd1;
            if (q.qidx == 2'd3) begin
                n.bidx = (byte_op && !last_bit) ? q.bidx + 4'd1 : 4'd0;
            end
        end

        // pins for the present quarter, registered
        n.scl  = 1'b1;
        n.sdo  = 1'b1;
        n.soe  = 1'b1;
        n.cond = 1'b1;
        if (active) begin
            case (op)
                OP_START: begin
                    n.scl = (q.qidx != 2'd3);
                    n.sdo = (q.qidx == 2'd0);
                end
                OP_STOP: begin
                    n.scl = (q.qidx != 2'd0);
                    n.sdo = q.qidx[1];
                end
                OP_WBYTE: begin
                    n.cond = 1'b0;
                    n.scl  = (q.qidx == 2'd1) || (q.qidx == 2'd2);
                    if (last_bit) n.soe = 1'b0;
                    else          n.sdo = tx_byte[3'd7 - q.bidx[2:0]];
                end
                default: begin
                    n.cond = 1'b0;
                    n.scl  = (q.qidx == 2'd1) || (q.qidx == 2'd2);
                    if (!last_bit) n.soe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.scl  <= 1'b1;
            q.sdo  <= 1'b1;
            q.soe  <= 1'b1;
            q.cond <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign rx_byte = q.rx;
    assign ninth   = q.ninth;
    assign scl_o   = q.scl;
    assign sda_o   = q.sdo;
    assign sda_oe  = q.soe;

    AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q.scl && $past(q.scl) && !q.cond && !$past(q.cond)) |-> ($stable(q.sdo) && $stable(q.soe))); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op == OP_WBYTE && q.bidx == 4'd8) |=> !sda_oe); // R6
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op == OP_RBYTE && q.bidx != 4'd8) |=> !sda_oe); // R6
    AST_NACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && op == OP_RBYTE && q.bidx == 4'd8) |=> (sda_oe && sda_o)); // R6

endmodule

// File: rtl/cam2w_master.sv
module cam2w_master
    import cam2w_pkg::*;
#(
    parameter int         SYS_CLK_HZ = 50_000_000,
    parameter int         SCL_HZ     = 100_000,
    parameter logic [6:0] DEV_ID7    = 7'h21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rd_nwr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] wr_data,
    output logic       busy,
    output logic       done,
    output logic       ack_ok,
    output logic [7:0] rd_data,
    output logic       scl_o,
    output logic       sda_o,
    output logic       sda_oe,
    input  logic       sda_i
);
    localparam int         QTR_CYC = SYS_CLK_HZ / (4 * SCL_HZ);
    localparam logic [7:0] ID_WR   = {DEV_ID7, 1'b0};
    localparam logic [7:0] ID_RD   = {DEV_ID7, 1'b1};

    seq_s       seq_q, seq_d;
    logic       accept;
    logic       tick;
    logic       cmd_end;
    logic       ninth;
    logic [7:0] rx_byte;
    logic [7:0] tx_byte;
    cam2w_op_e  cur_op;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        accept     = start && !seq_q.busy;
        cur_op     = seq_q.busy ? step_op(seq_q.rd, seq_q.step) : OP_START;

        case (seq_q.step)
            3'd1:    tx_byte = ID_WR;
            3'd2:    tx_byte = seq_q.addr;
            3'd3:    tx_byte = seq_q.wdata;
            3'd5:    tx_byte = ID_RD;
            default: tx_byte = 8'h00;
        endcase

        if (accept) begin
            seq_d.busy    = 1'b1;
            seq_d.rd      = rd_nwr;
            seq_d.step    = 3'd0;
            seq_d.addr    = reg_addr;
            seq_d.wdata   = wr_data;
            seq_d.ack_acc = 1'b1;
        end else if (seq_q.busy && cmd_end) begin
            if (cur_op == OP_WBYTE) seq_d.ack_acc = seq_q.ack_acc & ~ninth;
            if (seq_q.step == final_step(seq_q.rd)) begin
                seq_d.busy   = 1'b0;
                seq_d.done   = 1'b1;
                seq_d.step   = 3'd0;
                seq_d.ack_ok = seq_q.ack_acc;
                if (seq_q.rd) seq_d.rdata = rx_byte;
            end else begin
                seq_d.step = seq_q.step + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    cam2w_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (seq_q.busy),
        .restart (accept),
        .tick    (tick)
    );

    cam2w_phy u_phy (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (seq_q.busy),
        .clear   (accept),
        .tick    (tick),
        .op      (cur_op),
        .tx_byte (tx_byte),
        .sda_i   (sda_i),
        .cmd_end (cmd_end),
        .rx_byte (rx_byte),
        .ninth   (ninth),
        .scl_o   (scl_o),
        .sda_o   (sda_o),
        .sda_oe  (sda_oe)
    );

    assign busy    = seq_q.busy;
    assign done    = seq_q.done;
    assign ack_ok  = seq_q.ack_ok;
    assign rd_data = seq_q.rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(seq_q.addr) && $stable(seq_q.wdata) && $stable(seq_q.rd))); // R2
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(rd_data) && $stable(ack_ok))); // R10

endmodule

// File: tb/cam2w_master_bench.sv
module cam2w_master_bench;
    localparam int QTR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rd_nwr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       busy, done, ack_ok, scl_o, sda_o, sda_oe;
    logic [7:0] rd_data;
    logic       slv_low = 1'b0;
    wire        sda_w = (sda_oe ? sda_o : 1'b1) & ~slv_low;

    always #2 clk = ~clk;

    cam2w_master #(.SYS_CLK_HZ(4_000_000), .SCL_HZ(250_000), .DEV_ID7(7'h21)) u_cam2w_master (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .reg_addr(reg_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .ack_ok(ack_ok), .rd_data(rd_data), .scl_o(scl_o), .sda_o(sda_o),
        .sda_oe(sda_oe), .sda_i(sda_w)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0] smem [256];
    logic [7:0] ref_mem [256];
    int   ack_phase = 0;
    int   nack_at = -1;
    bit   cur_rd = 0;
    int   n_start = 0;
    int   n_stop = 0;
    logic nack_seen = 1'b0;
    int   collisions = 0;
    int   rise_cnt = 0;
    int   rise_t1 = 0;
    int   rise_t2 = 0;

    always @(negedge sda_w) if (scl_o === 1'b1) n_start++;
    always @(posedge sda_w) if (scl_o === 1'b1) n_stop++;
    always @(negedge clk) if (sda_oe && slv_low) collisions++;
    always @(posedge scl_o) begin
        rise_cnt++;
        if (rise_cnt == 1) rise_t1 = cyc;
        if (rise_cnt == 2) rise_t2 = cyc;
    end

    task automatic s_recv(output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_o);
            b = {b[6:0], sda_w};
        end
    endtask

    task automatic s_ack();
        @(negedge scl_o);
        repeat (QTR + 1) @(posedge clk);
        slv_low = (ack_phase != nack_at);
        ack_phase++;
        @(negedge scl_o);
        slv_low = 1'b0;
    endtask

    task automatic s_send(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            repeat (QTR + 1) @(posedge clk);
            slv_low = ~v[i];
            @(negedge scl_o);
        end
        slv_low = 1'b0;
    endtask

    initial begin : slave
        logic [7:0] id;
        logic [7:0] b;
        logic [7:0] ptr;
        ptr = 8'h00;
        for (int i = 0; i < 256; i++) begin
            smem[i]    = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        forever begin
            do @(negedge sda_w); while (scl_o !== 1'b1);
            s_recv(id);
            s_ack();
            if (id == 8'h42) begin
                s_recv(ptr);
                s_ack();
                if (!cur_rd) begin
                    s_recv(b);
                    s_ack();
                    smem[ptr] = b;
                end
            end else if (id == 8'h43) begin
                s_send(smem[ptr]);
                @(posedge scl_o);
                nack_seen = sda_w;
            end
        end
    end

    // ---------------- transaction driver ----------------
    logic [7:0] last_rd = 8'h00;

    task automatic txn(input bit rd, input logic [7:0] a, input logic [7:0] d,
                       input int nk, input bit poke);
        int   nq;
        logic exp_ack;
        logic [7:0] exp_rd;
        nq      = (rd ? 160 : 116) * QTR;
        exp_ack = (nk < 0 || nk > 2);
        exp_rd  = rd ? ref_mem[a] : last_rd;
        cur_rd = rd; nack_at = nk; ack_phase = 0;
        n_start = 0; n_stop = 0; rise_cnt = 0; nack_seen = 1'b0;
        @(negedge clk);
        rd_nwr = rd; reg_addr = a; wr_data = d; start = 1'b1;
        @(posedge clk);                       // accepting edge
        for (int c = 1; c < nq; c++) begin
            @(negedge clk);
            if (c == 1) begin
                start = 1'b0;
                chk(busy == 1'b1, "R8 busy after accept", busy, 1);
            end
            if (poke && c == 40) begin
                start = 1'b1; rd_nwr = ~rd; reg_addr = ~a; wr_data = ~d;
            end
            if (poke && c == 41) begin
                start = 1'b0; rd_nwr = rd; reg_addr = a; wr_data = d;
            end
            @(posedge clk);
        end
        @(negedge clk);
        chk(done == 1'b0, "R8 done early", done, 0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, "R8 done on time", done, 1);
        chk(busy == 1'b0, "R8 busy low at done", busy, 0);
        chk(ack_ok == exp_ack, "R7 ack status", ack_ok, exp_ack);
        chk(rd_data == exp_rd, rd ? "R4 read data" : "R10 rd_data held on write", rd_data, exp_rd);
        chk(n_start == (rd ? 2 : 1), rd ? "R4 start count" : "R3 start count", n_start, rd ? 2 : 1);
        chk(n_stop == (rd ? 2 : 1), rd ? "R4 stop count" : "R3 stop count", n_stop, rd ? 2 : 1);
        chk(rise_t2 - rise_t1 == 4 * QTR, "R9 scl period", rise_t2 - rise_t1, 4 * QTR);
        if (rd) begin
            chk(nack_seen == 1'b1, "R6 master nack", nack_seen, 1);
            last_rd = ref_mem[a];
        end else begin
            ref_mem[a] = d;
            chk(smem[a] == d, "R3 R5 byte stored", smem[a], d);
        end
        if (poke) chk(smem[~a] == ref_mem[~a], "R2 poked address untouched", smem[~a], ref_mem[~a]);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
    endtask

    initial begin : main
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 idle flags", {busy, done}, 0);
        chk(ack_ok == 0 && rd_data == 8'h00, "R1 result regs", {ack_ok, rd_data}, 0);
        chk(scl_o == 1 && sda_oe == 1 && sda_o == 1, "R1 bus idle", {scl_o, sda_oe, sda_o}, 3'b111);

        // untouched registers first
        for (int i = 0; i < 4; i++) txn(1'b1, 8'(i * 61 + 3), 8'h00, -1, 1'b0);
        // write sweep then read back
        for (int i = 0; i < 16; i++) txn(1'b0, 8'(i * 17), 8'(i * 37 + 5), -1, 1'b0);
        for (int i = 0; i < 16; i++) txn(1'b1, 8'(i * 17), 8'h00, -1, 1'b0);
        // missing acknowledge on each sent byte
        for (int p = 0; p < 3; p++) txn(1'b0, 8'h80 + 8'(p), 8'hC0 + 8'(p), p, 1'b0);
        for (int p = 0; p < 3; p++) txn(1'b1, 8'h80 + 8'(p), 8'h00, p, 1'b0);
        // start requests while busy
        txn(1'b0, 8'h3C, 8'hA5, -1, 1'b1);
        txn(1'b1, 8'h3C, 8'h00, -1, 1'b1);
        // write after read keeps rd_data
        txn(1'b0, 8'h07, 8'h19, -1, 1'b0);

        chk(collisions == 0, "R6 master released sda", collisions, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule